// File: doc/BRIEF.md
# Serial-Acknowledge Interrupt Priority Chain

This block models a row of interrupt-capable peripheral slots. All slots share one active-low request line toward a processor. A one-cycle service pulse on a slot's request input sets that slot's pending flag. Any pending flag holds the shared line low. Each slot also holds an identification byte, which software can reload and which resets to the slot index plus one.

The processor answers by raising an acknowledge level. On the rising edge the acknowledge passes through the slots in series, starting at slot 0, which has the highest priority. A slot that is not pending lets the acknowledge through to the next slot. The first pending slot keeps the acknowledge and puts its byte on the shared data bus. The bus is built as a one-hot selection of slot bytes. The winner's pending flag is then cleared. If the acknowledge reaches the end of the row without a taker, a no-responder flag is raised instead and the bus reads zero.

Top module: `daisy_ack_chain`

## Requirements
- R1: After reset all pending flags are clear, `irqN` is 1, `busData`, `idValid` and `noResponder` are 0, and the byte of slot i is i+1.
- R2: A 1 on `svcReq[i]` at a clock edge sets the pending flag of slot i, and `irqN` reads 0 after that edge.
- R3: `irqN` stays 0 while at least one slot is pending, including when several slots are pending together.
- R4: A clock edge at which `ackIn` is 1 and was 0 at the previous edge is a resolution edge. At a resolution edge the lowest-index pending slot wins, and after that edge `busData` holds its byte and `idValid` is 1.
- R5: The winner's pending flag clears at the resolution edge and the other flags are kept. `irqN` returns to 1 only once no slot is pending.
- R6: At a resolution edge with no slot pending, `noResponder` is 1 and `busData` and `idValid` are 0 for the following cycle.
- R7: Keeping `ackIn` high resolves only once. At the following edges, `idValid` and `noResponder` are 0 and no pending flag is cleared.
- R8: A request that arrives at a resolution edge does not change the winner of that edge. It becomes pending and can win at a later resolution edge.
- R9: A 1 on `idLoad[i]` at an edge stores `idData` as slot i's byte. Later wins by slot i present that byte.
- R10: After any edge that is not a resolution edge, `busData`, `idValid` and `noResponder` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| svcReq | input | NUM_SLOTS | Per-slot service request pulse |
| idLoad | input | NUM_SLOTS | Per-slot byte load strobe |
| idData | input | ID_W | Byte written by idLoad |
| ackIn | input | 1 | Acknowledge level from the processor |
| irqN | output | 1 | Shared request line, active low |
| busData | output | ID_W | Winner's byte, zero otherwise |
| idValid | output | 1 | busData carries a winner's byte |
| noResponder | output | 1 | Last resolution found no pending slot |

## Verification
A pending flag that is wrongly set or wrongly cleared shows up on `irqN` right after the edge that caused it. If the flag belongs to a lower-priority slot, it may also show up only at the next resolution, when the wrong byte or a missing winner appears on the bus. A broken ripple or broken edge detection shows in the cycle after the acknowledge rises, as a wrong byte, two flags raised together, or a repeated resolution while the acknowledge stays high. A corrupted byte register stays hidden until its slot wins.

// File: rtl/daisy_pkg.sv
package daisy_pkg;
  // strobes from chain control to datapath
  typedef struct packed {
    logic anyWin;
    logic noWin;
  } ctrlStrobes_t;
endpackage

// File: rtl/daisy_ctrl.sv
module daisy_ctrl
  import daisy_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ackIn,
  input  logic [NUM_SLOTS-1:0] pending,
  output logic [NUM_SLOTS-1:0] grant,
  output ctrlStrobes_t         strobes
);
  logic ackQ;
  logic ackFire;
  logic [NUM_SLOTS:0] ackChain;

  always_ff @(posedge clk) begin
    if (!rstN) ackQ <= 1'b0;
    else       ackQ <= ackIn;
  end

  assign ackFire     = ackIn & ~ackQ;
  assign ackChain[0] = ackFire;

  // serial pass: slot 0 sees the acknowledge first
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_link
    assign grant[i]      = ackChain[i] & pending[i];
    assign ackChain[i+1] = ackChain[i] & ~pending[i];
  end

  assign strobes.anyWin = |grant;
  assign strobes.noWin  = ackChain[NUM_SLOTS];

  // R4
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));
  // R7
  single_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackFire |=> !ackFire);
  // R6
  win_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.anyWin && strobes.noWin));
endmodule

// File: rtl/daisy_datapath.sv
module daisy_datapath
  import daisy_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ID_W      = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SLOTS-1:0] svcReq,
  input  logic [NUM_SLOTS-1:0] idLoad,
  input  logic [ID_W-1:0]      idData,
  input  logic [NUM_SLOTS-1:0] grant,
  input  ctrlStrobes_t         strobes,
  output logic [NUM_SLOTS-1:0] pending,
  output logic                 irqN,
  output logic [ID_W-1:0]      busData,
  output logic                 idValid,
  output logic                 noResponder
);
  logic [ID_W-1:0] idReg [NUM_SLOTS];
  logic [ID_W-1:0] busMux;

  always_comb begin
    busMux = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (grant[i]) busMux = busMux | idReg[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending     <= '0;
      busData     <= '0;
      idValid     <= 1'b0;
      noResponder <= 1'b0;
      for (int i = 0; i < NUM_SLOTS; i++) idReg[i] <= ID_W'(i + 1);
    end else begin
      pending     <= (pending & ~grant) | svcReq;
      busData     <= busMux;
      idValid     <= strobes.anyWin;
      noResponder <= strobes.noWin;
      for (int i = 0; i < NUM_SLOTS; i++)
        if (idLoad[i]) idReg[i] <= idData;
    end
  end

  assign irqN = ~|pending;

  // R4
  win_to_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.anyWin |=> idValid);
  // R6
  none_bus_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    noResponder |-> (busData == '0 && !idValid));
  // R2
  req_sets_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|svcReq) |=> !irqN);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slotChk
    // R5
    win_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
      (grant[i] && !svcReq[i]) |=> !pending[i]);
  end
endmodule

// File: rtl/daisy_ack_chain.sv
module daisy_ack_chain
  import daisy_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ID_W      = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SLOTS-1:0] svcReq,
  input  logic [NUM_SLOTS-1:0] idLoad,
  input  logic [ID_W-1:0]      idData,
  input  logic                 ackIn,
  output logic                 irqN,
  output logic [ID_W-1:0]      busData,
  output logic                 idValid,
  output logic                 noResponder
);
  logic [NUM_SLOTS-1:0] pending;
  logic [NUM_SLOTS-1:0] grant;
  ctrlStrobes_t         strobes;

  daisy_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .ackIn(ackIn), .pending(pending),
    .grant(grant), .strobes(strobes)
  );

  daisy_datapath #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .svcReq(svcReq), .idLoad(idLoad), .idData(idData),
    .grant(grant), .strobes(strobes), .pending(pending), .irqN(irqN),
    .busData(busData), .idValid(idValid), .noResponder(noResponder)
  );
endmodule

// File: tb/sim_daisy_ack_chain.sv
module sim_daisy_ack_chain;
  localparam int PERIOD = 10;
  localparam int N = 4;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN;
  logic [N-1:0] svcReq, idLoad;
  logic [W-1:0] idData;
  logic ackIn;
  logic irqN, idValid, noResponder;
  logic [W-1:0] busData;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [N-1:0] mPend;
  logic [W-1:0] mId [N];
  logic mAckPrev;

  always #(PERIOD/2) clk = ~clk;

  daisy_ack_chain #(.NUM_SLOTS(N), .ID_W(W)) u0 (
    .clk(clk), .rstN(rstN), .svcReq(svcReq), .idLoad(idLoad), .idData(idData),
    .ackIn(ackIn), .irqN(irqN), .busData(busData), .idValid(idValid),
    .noResponder(noResponder)
  );

  function automatic int lowestPending(logic [N-1:0] p);
    for (int i = 0; i < N; i++) if (p[i]) return i;
    return -1;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // drive at negedge, check after the following posedge
  task automatic step(string tag, logic [N-1:0] s, logic [N-1:0] ld,
                      logic [W-1:0] d, logic a);
    int win;
    logic [W-1:0] eBus;
    logic eVal, eNone;
    svcReq = s; idLoad = ld; idData = d; ackIn = a;
    eBus = '0; eVal = 0; eNone = 0;
    if (a && !mAckPrev) begin
      win = lowestPending(mPend);
      if (win < 0) eNone = 1;
      else begin eVal = 1; eBus = mId[win]; mPend[win] = 1'b0; end
    end
    mPend = mPend | s;
    for (int i = 0; i < N; i++) if (ld[i]) mId[i] = d;
    mAckPrev = a;
    @(posedge clk);
    #(PERIOD/4);
    cmp(tag, "busData", int'(busData), int'(eBus));
    cmp(tag, "idValid", int'(idValid), int'(eVal));
    cmp(tag, "noResponder", int'(noResponder), int'(eNone));
    cmp(tag, "irqN", int'(irqN), int'(mPend == '0));
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 0; svcReq = '0; idLoad = '0; idData = '0; ackIn = 0;
    mPend = '0; mAckPrev = 0;
    for (int i = 0; i < N; i++) mId[i] = W'(i + 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1 reset state
    cmp("R1", "irqN", int'(irqN), 1);
    cmp("R1", "busData", int'(busData), 0);
    cmp("R1", "idValid", int'(idValid), 0);
    cmp("R1", "noResponder", int'(noResponder), 0);
    // R6 ack with nothing pending
    step("R6", '0, '0, '0, 1);
    step("R7", '0, '0, '0, 1);
    step("R10", '0, '0, '0, 0);
    // R1 default ids: slot i byte i+1
    step("R2", 4'b0100, '0, '0, 0);
    step("R1", '0, '0, '0, 1);
    step("R10", '0, '0, '0, 0);
    // R3 several pending, R4 priority order, R5 line held until last
    step("R3", 4'b1010, '0, '0, 0);
    step("R3", 4'b0001, '0, '0, 0);
    for (int k = 0; k < 3; k++) begin
      step("R4", '0, '0, '0, 1);
      step("R5", '0, '0, '0, 0);
    end
    step("R6", '0, '0, '0, 1);
    step("R10", '0, '0, '0, 0);
    // R7 held ack with pending does not clear
    step("R7", 4'b0110, '0, '0, 0);
    step("R4", '0, '0, '0, 1);
    step("R7", '0, '0, '0, 1);
    step("R7", '0, '0, '0, 1);
    step("R10", '0, '0, '0, 0);
    // R8 higher-priority request at resolution edge does not win now
    step("R8", 4'b0001, '0, '0, 1);
    step("R10", '0, '0, '0, 0);
    step("R8", '0, '0, '0, 1);
    step("R10", '0, '0, '0, 0);
    // R9 byte reload
    step("R9", 4'b1000, 4'b1000, 8'hA5, 0);
    step("R9", '0, '0, '0, 1);
    step("R10", '0, '0, '0, 0);
    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [N-1:0] s, l;
      s = (($urandom % 3) == 0) ? N'($urandom) : '0;
      l = (($urandom % 8) == 0) ? N'($urandom) : '0;
      step("R4", s, l, W'($urandom), (($urandom % 3) == 0));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule